// File: doc/BRIEF.md
# Strobe-Written Asynchronous RAM

This block is a small RAM whose two control inputs are active-low strobes instead of a clock. The write strobe is itself the storage clock: a word is stored when the strobe goes from low back to high. The stored word is the one selected by the address held during the strobe, and the value is whatever is on the write data bus at that edge. The read side has no clock. While the output-enable strobe is low, the read data bus shows the word at the current address. While it is high, the bus is forced to zero; it is never left floating.

The user keeps a simple discipline. The two strobes are never low together. Before either strobe is lowered, the other must already have been high for a while. The address must not move while the write strobe is low or at the moment it rises. An asynchronous active-low reset clears every word to zero. Data width and address width are parameters, and the depth is two to the power of the address width.

Top module: `strobe_ram`

## Requirements
- R1: While `rst_n` is low, every word is cleared to zero. After `rst_n` is released, reading any address returns zero until that address is written.
- R2: While `oe_n` is high, `rd_data` is exactly zero, whatever the memory holds and whatever `addr` is.
- R3: While `oe_n` is low, `rd_data` equals the word at `addr`. The path is combinational: changing `addr` changes `rd_data` with no clock edge.
- R4: On a rising edge of `wr_n`, the word at `addr` takes the value of `wr_data`. This holds when `addr` is stable from the falling edge of `wr_n` through its rise and `oe_n` stays high throughout. The two strobes are never low at the same time.
- R5: Only the value on `wr_data` at the rising edge of `wr_n` is stored. Values driven earlier in the low phase, or after the rise, leave the word unchanged.
- R6: A write leaves every word at another address unchanged, and a later write to the same address replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all words |
| addr | input | ADDR_W | Shared word address for reads and writes |
| wr_data | input | DATA_W | Data to be stored at the write strobe rise |
| wr_n | input | 1 | Active-low write strobe; rising edge stores |
| oe_n | input | 1 | Active-low output enable for the read bus |
| rd_data | output | DATA_W | Addressed word while enabled, zero otherwise |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 5-bit address. At that size every one of the 32 addresses can be swept in each phase. The phases are the cleared state after both resets, the forced-zero bus, combinational address changes under an enabled read, and two full write passes. Each pass writes a distinct computed pattern, so a wrong decode, a stuck data bit or a word that fails to update shows up as a specific address mismatch. A single-word write followed by a full read sweep confirms that neighbouring words are left alone. Data is changed before and after each strobe rise to show that only the value at the edge is kept.

// File: rtl/strobe_ram_pkg.sv
package strobe_ram_pkg;
  localparam int unsigned DFLT_DATA_W = 32;
  localparam int unsigned DFLT_ADDR_W = 5;

  function automatic int unsigned depth_of(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [DEPTH-1:0]  sel
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel[i] = en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/sram_word_cell.sv
module sram_word_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/sram_read_gate.sv
module sram_read_gate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] words,
  input  logic [DEPTH-1:0]             rsel,
  output logic [DATA_W-1:0]            data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rsel[i]) data = data | words[i];
    end
  end
endmodule

// File: rtl/strobe_ram.sv
module strobe_ram
  import strobe_ram_pkg::*;
#(
  parameter int unsigned DATA_W = DFLT_DATA_W,
  parameter int unsigned ADDR_W = DFLT_ADDR_W
) (
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = depth_of(ADDR_W);

  logic [DEPTH-1:0]             wsel;
  logic [DEPTH-1:0]             rsel;
  logic [DEPTH-1:0][DATA_W-1:0] words;

  // write select: evaluated continuously, consumed only at the wr_n rise
  sram_addr_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wdec (
    .addr (addr),
    .en   (1'b1),
    .sel  (wsel)
  );

  // read select: empty while output enable is high, forcing a zero bus
  sram_addr_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rdec (
    .addr (addr),
    .en   (!oe_n),
    .sel  (rsel)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    sram_word_cell #(.DATA_W(DATA_W)) u_cell (
      .wr_clk (wr_n),
      .rst_n  (rst_n),
      .load   (wsel[i]),
      .d      (wr_data),
      .q      (words[i])
    );
  end

  sram_read_gate #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rgate (
    .words (words),
    .rsel  (rsel),
    .data  (rd_data)
  );
endmodule

// File: rtl/strobe_ram_chk.sv
module strobe_ram_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] addr_hold;
  logic              hold_vld;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  logic              last_vld;

  always_ff @(negedge wr_n or negedge rst_n) begin
    if (!rst_n) begin
      addr_hold <= '0;
      hold_vld  <= 1'b0;
    end else begin
      addr_hold <= addr;
      hold_vld  <= 1'b1;
    end
  end

  always_ff @(posedge wr_n or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_data <= '0;
      last_vld  <= 1'b0;
    end else begin
      last_addr <= addr;
      last_data <= wr_data;
      last_vld  <= 1'b1;
    end
  end

  // R4: strobes never low together
  a_r4_wr_needs_oe_high: assert property (@(negedge wr_n) disable iff (!rst_n) oe_n);
  a_r4_oe_needs_wr_high: assert property (@(negedge oe_n) disable iff (!rst_n) wr_n);

  // R4: address held from strobe fall through its rise
  a_r4_addr_stable: assert property (@(posedge wr_n) disable iff (!rst_n)
    hold_vld |-> (addr == addr_hold));

  // R2: bus reads zero across a write, since output enable is high then
  a_r2_zero_during_write: assert property (@(posedge wr_n) disable iff (!rst_n)
    rd_data == '0);

  // R4/R6: a read of the most recently written address returns that data
  a_r4_readback_last: assert property (@(posedge oe_n) disable iff (!rst_n)
    (last_vld && addr == last_addr) |-> (rd_data == last_data));
endmodule

bind strobe_ram strobe_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_data (wr_data),
  .wr_n    (wr_n),
  .oe_n    (oe_n),
  .rd_data (rd_data)
);

// File: tb/sim_strobe_ram.sv
`timescale 1ns/1ps
module sim_strobe_ram;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic          wr_n;
  logic          oe_n;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] expm [DEPTH];

  always #10 clk = ~clk;

  strobe_ram #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_n(wr_n), .oe_n(oe_n), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'(p) << 8) ^ 32'(p * 7 + 1);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) expm[i] = '0;
    @(negedge clk);
  endtask

  // junk data before and after the rise; the proper value only at the edge (R5)
  task automatic write_word(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    addr    = AW'(a);
    wr_data = ~d;
    @(negedge clk);
    wr_n = 1'b0;
    @(negedge clk);
    wr_data = d ^ 32'h5A5A_0F0F;
    @(negedge clk);
    wr_data = d;
    @(negedge clk);
    wr_n = 1'b1;
    expm[a] = d;
    #3 wr_data = ~d + 32'd3;
    @(negedge clk);
  endtask

  task automatic read_word(input int a, input string req);
    @(negedge clk);
    addr = AW'(a);
    #2 check("R2", rd_data, '0);
    oe_n = 1'b0;
    #3 check(req, rd_data, expm[a]);
    @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    fails++;
    checks++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_data = '0; wr_n = 1'b1; oe_n = 1'b1;
    do_reset();

    // R1: every word zero after reset
    for (int a = 0; a < DEPTH; a++) read_word(a, "R1");

    // R4: first full write pass, then readback
    for (int a = 0; a < DEPTH; a++) write_word(a, pat(a, 1));
    for (int a = 0; a < DEPTH; a++) read_word(a, "R4");

    // R2: bus stays zero with output enable high across all addresses
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr = AW'(a);
      #2 check("R2", rd_data, '0);
    end

    // R3: combinational follow of address with enable held low
    @(negedge clk);
    oe_n = 1'b0;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      #2 addr = AW'(a);
      #1 check("R3", rd_data, expm[a]);
    end
    #2 oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R6: single write, others untouched
    write_word(17, 32'hC0DE_1717);
    for (int a = 0; a < DEPTH; a++) read_word(a, (a == 17) ? "R4" : "R6");

    // R5: only the edge value is kept
    write_word(3, 32'h0000_0003);
    read_word(3, "R5");
    write_word(3, 32'hFFFF_FFFC);
    read_word(3, "R5");

    // R6: second pass overwrites each word
    for (int a = 0; a < DEPTH; a++) write_word(a, pat(a, 2));
    for (int a = 0; a < DEPTH; a++) read_word(a, "R6");

    // R1: reset mid-run clears everything
    do_reset();
    for (int a = 0; a < DEPTH; a++) read_word(a, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule